// File: doc/BRIEF.md
# Pad Pull Resistor Control Sequencer

This block holds the pull-resistor setting for a bank of pads and applies it through a strobe protocol. Software first writes a 2-bit pull mode into one shared mode register. The mode goes out on a line that every pad sees. A pad takes the mode only when software raises that pad's bit in one of the pad-strobe words. The block keeps the latched pull setting of every pad and drives it out as one flat vector.

The strobe protocol has timing rules. The mode must be stable for a minimum number of clock cycles before a strobe rises (setup). It must also stay unchanged for a minimum number of cycles after a strobe rises (hold). The block counts both intervals. If a strobe rises too early, the pad does not capture and a sticky flag is raised. If the mode is rewritten too soon after a strobe, a separate sticky flag is raised. A strobe that would capture the reserved mode code also leaves the pad unchanged and sets its own sticky flag.

The strobe side is tracked by a three-state machine:
- `PH_OPEN`: no strobe bit is set.
- `PH_HOLD`: at least one strobe is set and the hold window from the most recent rising strobe is still running.
- `PH_HELD`: strobes are set and the hold window has elapsed.

The machine moves between these states as follows:
- Any rising strobe moves it to `PH_HOLD` from any state.
- Clearing all strobes moves it to `PH_OPEN`.
- Reaching the end of the hold window moves it from `PH_HOLD` to `PH_HELD`.

Top module: `pad_pull_seq`

## Requirements
- R1: After reset every pad's pull field reads 00, the mode register holds 00, no strobe bit is set, and all three flags are 0.
- R2: A write to word address 37 stores bits 1:0 as the mode. The codes are 00 = no pull, 01 = pull-down, 10 = pull-up, 11 = reserved. When a pad's strobe bit goes 0→1 with setup met, the pad's field `pull_state[2i+1:2i]` takes the mode, visible after that write's clock edge.
- R3: Only a 0→1 change of a strobe bit captures. Rewriting a bit that is already 1, or writing 0, leaves that pad's field unchanged.
- R4: Word address 38 bit j strobes pad j (pads 0..31). Word address 39 bit j strobes pad 32+j (pads 32..53). Bits 31:22 of word 39 and writes to any other address change nothing.
- R5: Setup is met when the strobe write's clock edge comes at least SETUP_CYC edges after the edge of the most recent mode write, or when no mode write has occurred since reset. If a strobe rises without setup met, that pad keeps its field and `setup_viol` sets.
- R6: A rising strobe with setup met while the mode is 11 leaves the pad's field unchanged and sets `rsvd_err`. No pad field ever holds 11.
- R7: A mode write sets `hold_viol` when it lands while some strobe bit is set and fewer than HOLD_CYC edges have passed since the most recent rising strobe. At HOLD_CYC edges or more, or with all strobes clear, a mode write sets no flag.
- R8: `setup_viol`, `hold_viol` and `rsvd_err` stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Word address of the write |
| wr_data | input | 32 | Write data |
| pull_state | output | 108 | Latched pull field per pad, 2 bits per pad, pad i at bits 2i+1:2i |
| setup_viol | output | 1 | Sticky: a strobe rose before the setup interval elapsed |
| hold_viol | output | 1 | Sticky: the mode changed inside the hold interval |
| rsvd_err | output | 1 | Sticky: a strobe tried to capture the reserved code |

## Verification
The hardest situations to reach are the exact edges of the two windows. These are a strobe that lands exactly SETUP_CYC or SETUP_CYC−1 edges after a mode write, and a mode write exactly HOLD_CYC or HOLD_CYC−1 edges after a rising strobe. Random gaps almost never hit them. Directed sequences therefore place the second write with a counted idle gap, so both the passing and the failing side of each boundary occur.

A second hard case is a strobe bit rewritten while it is already set. Random strobe words reach it only occasionally, so it is forced directly.

The random phase mixes mode writes, strobe writes to both words and to unmapped addresses, idle gaps and occasional resets. A bench model that numbers clock edges supplies the expected values.

// File: rtl/pad_pull_pkg.sv
package pad_pull_pkg;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_DOWN = 2'b01,
        PULL_UP   = 2'b10,
        PULL_RSVD = 2'b11
    } pull_mode_e;

    typedef enum logic [1:0] {
        PH_OPEN = 2'b00,
        PH_HOLD = 2'b01,
        PH_HELD = 2'b10
    } strobe_phase_e;

endpackage

// File: rtl/pad_pull_timer.sv
// Saturating interval counter: restart loads 1, then it counts up to LIMIT.
module pad_pull_timer #(
    parameter int LIMIT = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(LIMIT);
        end else if (restart) begin
            cnt_q <= CW'(1);
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = (cnt_q == CW'(LIMIT));
    assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pad_pull_latch.sv
// One pad: its strobe bit and its latched pull field.
module pad_pull_latch
    import pad_pull_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       word_hit,
    input  logic       word_bit,
    input  logic       setup_ok,
    input  pull_mode_e mode,
    output logic       strobe_q,
    output logic       strobe_d,
    output logic       rise,
    output logic       setup_miss,
    output logic       rsvd_hit,
    output logic [1:0] field
);
    logic capture;

    assign strobe_d   = word_hit ? word_bit : strobe_q;
    assign rise       = strobe_d & ~strobe_q;
    assign setup_miss = rise & ~setup_ok;
    assign rsvd_hit   = rise & setup_ok & (mode == PULL_RSVD);
    assign capture    = rise & setup_ok & (mode != PULL_RSVD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            field    <= 2'b00;
        end else begin
            strobe_q <= strobe_d;
            if (capture) begin
                field <= mode;
            end
        end
    end
endmodule

// File: rtl/pad_pull_seq.sv
module pad_pull_seq
    import pad_pull_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int MODE_ADDR = 37,
    parameter int STRB_ADDR = 38,
    parameter int SETUP_CYC = 150,
    parameter int HOLD_CYC  = 150
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [WORD_W-1:0]     wr_data,
    output logic [2*NUM_PINS-1:0] pull_state,
    output logic                  setup_viol,
    output logic                  hold_viol,
    output logic                  rsvd_err
);
    localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;

    pull_mode_e      mode_q;
    logic            mode_wr;
    logic            setup_ok;
    logic            setup_last;
    logic            hold_done;
    logic            hold_last;
    logic [NUM_PINS-1:0] strobe_q, strobe_d, rise_v, miss_v, rsvd_v;
    logic [NUM_WORDS-1:0] word_hit;
    logic            any_rise, any_strobe_d, hold_breach;
    strobe_phase_e   phase_q, phase_d;

    // ---------------- write decode ----------------
    assign mode_wr = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign word_hit[w] = wr_en && (wr_addr == ADDR_W'(STRB_ADDR + w));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PULL_NONE;
        end else if (mode_wr) begin
            mode_q <= pull_mode_e'(wr_data[1:0]);
        end
    end

    // ---------------- interval timers ----------------
    pad_pull_timer #(.LIMIT(SETUP_CYC)) u_setup_tmr (
        .clk(clk), .rst_n(rst_n), .restart(mode_wr),
        .done(setup_ok), .last(setup_last)
    );

    pad_pull_timer #(.LIMIT(HOLD_CYC)) u_hold_tmr (
        .clk(clk), .rst_n(rst_n), .restart(any_rise),
        .done(hold_done), .last(hold_last)
    );

    // ---------------- per-pad latches ----------------
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
        localparam int WIDX = i / WORD_W;
        localparam int BIDX = i % WORD_W;
        pad_pull_latch u_pad (
            .clk        (clk),
            .rst_n      (rst_n),
            .word_hit   (word_hit[WIDX]),
            .word_bit   (wr_data[BIDX]),
            .setup_ok   (setup_ok),
            .mode       (mode_q),
            .strobe_q   (strobe_q[i]),
            .strobe_d   (strobe_d[i]),
            .rise       (rise_v[i]),
            .setup_miss (miss_v[i]),
            .rsvd_hit   (rsvd_v[i]),
            .field      (pull_state[2*i +: 2])
        );
    end

    assign any_rise     = |rise_v;
    assign any_strobe_d = |strobe_d;

    // ---------------- strobe phase machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_OPEN;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        phase_d     = phase_q;
        hold_breach = 1'b0;
        unique case (phase_q)
            PH_OPEN: begin
                if (any_rise) phase_d = PH_HOLD;
            end
            PH_HOLD: begin
                hold_breach = mode_wr;
                if (any_rise)          phase_d = PH_HOLD;
                else if (!any_strobe_d) phase_d = PH_OPEN;
                else if (hold_last)     phase_d = PH_HELD;
            end
            PH_HELD: begin
                if (any_rise)          phase_d = PH_HOLD;
                else if (!any_strobe_d) phase_d = PH_OPEN;
            end
            default: phase_d = PH_OPEN;
        endcase
    end

    // ---------------- sticky flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_viol <= 1'b0;
            hold_viol  <= 1'b0;
            rsvd_err   <= 1'b0;
        end else begin
            if (|miss_v)     setup_viol <= 1'b1;
            if (hold_breach) hold_viol  <= 1'b1;
            if (|rsvd_v)     rsvd_err   <= 1'b1;
        end
    end

endmodule

// File: rtl/pad_pull_seq_chk.sv
module pad_pull_seq_chk #(
    parameter int NUM_PINS  = 54,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int MODE_ADDR = 37,
    parameter int STRB_ADDR = 38
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [2*NUM_PINS-1:0] pull_state,
    input logic                  setup_viol,
    input logic                  hold_viol,
    input logic                  rsvd_err
);
    localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;

    logic mode_wr, strb_wr, any_rsvd_field;

    assign mode_wr = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
    assign strb_wr = wr_en && (wr_addr >= ADDR_W'(STRB_ADDR))
                           && (wr_addr <  ADDR_W'(STRB_ADDR + NUM_WORDS));

    always_comb begin
        any_rsvd_field = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (pull_state[2*i +: 2] == 2'b11) any_rsvd_field = 1'b1;
        end
    end

    // R6: the reserved code never reaches a pad field
    a_r6_no_reserved_field: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rsvd_field);

    // R3 / R4: pad fields move only on a strobe-word write
    a_r4_fields_need_strobe_write: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_wr |=> $stable(pull_state));

    // R5: a setup violation appears only through a strobe-word write
    a_r5_setup_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_wr |=> !$rose(setup_viol));

    // R7: a hold violation appears only through a mode write
    a_r7_hold_from_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> !$rose(hold_viol));

    // R8: flags are sticky
    a_r8_setup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        setup_viol |=> setup_viol);
    a_r8_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hold_viol |=> hold_viol);
    a_r8_rsvd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_err |=> rsvd_err);

endmodule

bind pad_pull_seq pad_pull_seq_chk #(
    .NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .MODE_ADDR(MODE_ADDR), .STRB_ADDR(STRB_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .pull_state(pull_state), .setup_viol(setup_viol),
    .hold_viol(hold_viol), .rsvd_err(rsvd_err)
);

// File: tb/pad_pull_seq_bench.sv
module pad_pull_seq_bench;
    localparam int NP    = 54;
    localparam int SETUP = 150;
    localparam int HOLD  = 150;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [2*NP-1:0] pull_state;
    logic          setup_viol, hold_viol, rsvd_err;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;

    // model state
    bit [1:0] m_field [NP];
    bit       m_strb  [NP];
    bit [1:0] m_mode;
    bit       m_sv, m_hv, m_re;
    bit       ctrl_seen, rise_seen;
    longint   last_ctrl, last_rise;

    pad_pull_seq #(.NUM_PINS(NP), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) u_pad_pull_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pull_state(pull_state), .setup_viol(setup_viol),
        .hold_viol(hold_viol), .rsvd_err(rsvd_err)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic void model_reset();
        for (int i = 0; i < NP; i++) begin m_field[i] = 2'b00; m_strb[i] = 1'b0; end
        m_mode = 2'b00; m_sv = 0; m_hv = 0; m_re = 0;
        ctrl_seen = 0; rise_seen = 0; last_ctrl = 0; last_rise = 0;
    endfunction

    function automatic bit any_strobe();
        bit a = 0;
        for (int i = 0; i < NP; i++) a |= m_strb[i];
        return a;
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [31:0] d, input longint e);
        bit setup_ok, rose;
        if (a == 8'd37) begin
            if (any_strobe() && rise_seen && (e - last_rise < HOLD)) m_hv = 1;
            m_mode = d[1:0]; ctrl_seen = 1; last_ctrl = e;
        end else if (a == 8'd38 || a == 8'd39) begin
            setup_ok = !ctrl_seen || (e - last_ctrl >= SETUP);
            rose = 0;
            for (int i = 0; i < NP; i++) begin
                bit nb;
                if (a == 8'd38 && i < 32)       nb = d[i];
                else if (a == 8'd39 && i >= 32) nb = d[i-32];
                else continue;
                if (nb && !m_strb[i]) begin
                    rose = 1;
                    if (!setup_ok)          m_sv = 1;
                    else if (m_mode == 2'b11) m_re = 1;
                    else                    m_field[i] = m_mode;
                end
                m_strb[i] = nb;
            end
            if (rose) begin rise_seen = 1; last_rise = e; end
        end
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        model_write(a, d, cyc + 1);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk1(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [2*NP-1:0] exp;
        for (int i = 0; i < NP; i++) exp[2*i +: 2] = m_field[i];
        chk1(tag, "pull_state", 128'(pull_state), 128'(exp));
        chk1(tag, "setup_viol", 128'(setup_viol), 128'(m_sv));
        chk1(tag, "hold_viol",  128'(hold_viol),  128'(m_hv));
        chk1(tag, "rsvd_err",   128'(rsvd_err),   128'(m_re));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        check_all("R1");

        // R2: pull-up into pads 0,4..7
        wr(8'd37, 32'h2); idle(SETUP);
        wr(8'd38, 32'h0000_00F1);
        check_all("R2");
        idle(HOLD);
        wr(8'd37, 32'h0); check_all("R7");
        wr(8'd38, 32'h0);

        // R4: upper word mapping, ignored bits, foreign addresses
        wr(8'd37, 32'hFFFF_FFF1); idle(SETUP);
        wr(8'd39, 32'hFFC0_0001);
        check_all("R4");
        wr(8'd40, 32'hFFFF_FFFF);
        wr(8'd36, 32'hFFFF_FFFF);
        check_all("R4");

        // R3: already-set strobe bit does not recapture
        idle(HOLD);
        wr(8'd37, 32'h2); idle(SETUP);
        wr(8'd39, 32'h1);
        check_all("R3");
        wr(8'd39, 32'h3);
        check_all("R3");

        // R5: setup boundary both sides
        do_reset();
        wr(8'd37, 32'h1); idle(SETUP - 2);
        wr(8'd38, 32'h200);
        check_all("R5");
        wr(8'd38, 32'h0);
        wr(8'd37, 32'h2); idle(SETUP - 3);
        wr(8'd38, 32'h400);
        check_all("R5");
        idle(50);
        check_all("R8");

        // R6: reserved code leaves the pad as it was
        do_reset();
        wr(8'd37, 32'h2); idle(SETUP);
        wr(8'd38, 32'h8); idle(HOLD);
        wr(8'd38, 32'h0);
        wr(8'd37, 32'h3); idle(SETUP);
        wr(8'd38, 32'h8);
        check_all("R6");

        // R7: hold boundary both sides
        do_reset();
        wr(8'd37, 32'h1); idle(SETUP);
        wr(8'd38, 32'h4); idle(HOLD - 2);
        wr(8'd37, 32'h0);
        check_all("R7");
        wr(8'd38, 32'h0);
        wr(8'd37, 32'h1); idle(SETUP);
        wr(8'd38, 32'h4); idle(HOLD - 3);
        wr(8'd37, 32'h0);
        check_all("R7");
        idle(20);
        check_all("R8");

        // constrained random mix
        void'($urandom(32'h5A17_C0DE));
        for (int n = 0; n < 300; n++) begin
            int op = $urandom_range(0, 99);
            if (op < 3) begin
                do_reset();
                check_all("R1");
            end else if (op < 30) begin
                wr(8'd37, 32'($urandom_range(0, 3)));
                check_all("R7");
            end else if (op < 50) begin
                wr(8'd38, $urandom() & $urandom());
                check_all("R2");
            end else if (op < 70) begin
                wr(8'd39, $urandom() & $urandom());
                check_all("R4");
            end else if (op < 75) begin
                wr(8'(36 + $urandom_range(0, 1) * 4), $urandom());
                check_all("R4");
            end else begin
                idle($urandom_range(0, 200));
                check_all("R5");
            end
        end

        summary();
        $finish;
    end
endmodule